// File: doc/BRIEF.md
# Banked Interrupt Source Controller

This block gathers up to 160 peripheral interrupt inputs, grouped into five banks of 32, and presents one request line per bank to the processor. Each input passes through a two-flop synchroniser. It then sets a latched pending flag, either while it sits at its active level or on an edge of the chosen direction. Software programs the block through a plain register port, with one write strobe, a byte address, write data and combinational read data. Through that port it enables sources, chooses the active sense and the trigger kind for each source, forces pending flags, and acknowledges pending flags by writing ones.

Source number k lives in bank k / 32 at bit k mod 32. Each bank owns a 24-byte window that starts at byte address bank × 24. The window holds six word registers, and each is written and read as a whole 32-bit word. A bank's request line is high whenever one of its pending flags is also enabled, so the processor side only has to find which bank is asking and then scan that bank's pending word.

Top module: `pirq_hub`

## Requirements
- R1: After reset, every enable bit and every pending bit is 0, every sense bit is 1, every trigger-kind bit is 0 (level), and every request line is low.
- R2: Register offsets within a bank window are 0x0 pending (read-only, writes ignored), 0x4 enable, 0x8 set-pending, 0xC clear-pending, 0x10 sense and 0x14 trigger kind. Enable, sense and trigger kind read back the last value written. The set and clear offsets read as 0.
- R3: A change on a source input first affects its pending bit at the third rising clock edge after the change.
- R4: With trigger kind 0, a source whose synchronised input is at its active level (high when sense is 1, low when sense is 0) sets its pending bit. The bit stays set until it is cleared, and it only becomes set through a trigger or a set-pending write.
- R5: Writing a 1 to a clear-pending bit clears that pending bit, and 0 bits leave it unchanged. A level-triggered source whose input is still active remains pending.
- R6: With trigger kind 1, a rising input (sense 1) or a falling input (sense 0) sets the pending bit, which holds after the input returns until it is cleared. An edge in the opposite direction has no effect.
- R7: When a clear-pending write and a qualifying edge of the same source land on the same clock edge, the pending bit ends up set.
- R8: Writing a 1 to a set-pending bit makes that source pending. Bits written as 0 leave the pending word unchanged.
- R9: Request line n is high exactly when bank n has a bit that is both pending and enabled.
- R10: A write affects only the bank its address selects. Writes to unaligned addresses or to addresses beyond the last bank are ignored, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 160 | Raw interrupt inputs, source k at bit k |
| wr_en | input | 1 | Register write strobe, taken on the rising edge |
| addr | input | 8 | Byte address of the register being accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| cpu_req | output | 5 | One request line per bank |

## Verification
Directed sequences first look at the exact cycle in which an input reaches its pending bit. They then set level sources against clear writes, so that an acknowledge which sticks can be told apart from one that the still-active input re-asserts. Edge sources are driven in both directions under both sense settings, which separates a true edge detector from a level detector and catches an inverted sense. One sequence lands a clear and a fresh edge on the same clock edge to show which of the two takes priority. Random toggling of inputs, mixed with random writes to every register of every bank, then checks that the banks stay independent and that the request lines track pending and enable under mixed modes.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // Byte distance between consecutive bank windows.
  localparam int unsigned REG_STRIDE = 24;

  typedef enum logic [2:0] {
    RS_STAT = 3'd0,
    RS_EN   = 3'd1,
    RS_SET  = 3'd2,
    RS_CLR  = 3'd3,
    RS_POL  = 3'd4,
    RS_EDGE = 3'd5
  } reg_sel_e;

  function automatic int unsigned bank_of(input int unsigned a);
    return a / REG_STRIDE;
  endfunction

  function automatic reg_sel_e reg_of(input int unsigned a);
    return reg_sel_e'(3'((a % REG_STRIDE) >> 2));
  endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int W      = 160,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pirq_bank.sv
module pirq_bank #(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] src_s,
  input  logic [BW-1:0] set_mask,
  input  logic [BW-1:0] clr_mask,
  input  logic          we_en,
  input  logic          we_pol,
  input  logic          we_edge,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] pend,
  output logic [BW-1:0] en,
  output logic [BW-1:0] pol,
  output logic [BW-1:0] edg,
  output logic [BW-1:0] trig,
  output logic          req
);
  logic [BW-1:0] src_d;
  logic [BW-1:0] act_now;
  logic [BW-1:0] act_old;

  // Active-state view of an input under the given sense bits.
  function automatic logic [BW-1:0] active(input logic [BW-1:0] v, input logic [BW-1:0] p);
    return ~(v ^ p);
  endfunction

  // Pending update: a new trigger or set outranks a clear.
  function automatic logic [BW-1:0] next_pend(input logic [BW-1:0] p, input logic [BW-1:0] t,
                                              input logic [BW-1:0] s, input logic [BW-1:0] c);
    return (p & ~c) | t | s;
  endfunction

  always_comb begin
    act_now = active(src_s, pol);
    act_old = active(src_d, pol);
    trig    = (edg & act_now & ~act_old) | (~edg & act_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d <= '0;
      pend  <= '0;
      en    <= '0;
      pol   <= '1;
      edg   <= '0;
    end else begin
      src_d <= src_s;
      pend  <= next_pend(pend, trig, set_mask, clr_mask);
      if (we_en)   en  <= wdata;
      if (we_pol)  pol <= wdata;
      if (we_edge) edg <= wdata;
    end
  end

  assign req = |(pend & en);
endmodule

// File: rtl/pirq_hub.sv
module pirq_hub #(
  parameter int NUM_BANKS   = 5,
  parameter int BANK_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   src_in,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BANK_W-1:0]             wdata,
  output logic [BANK_W-1:0]             rdata,
  output logic [NUM_BANKS-1:0]          cpu_req
);
  import pirq_pkg::*;

  localparam int NSRC = NUM_BANKS * BANK_W;

  logic [NSRC-1:0] src_s;
  logic [NSRC-1:0] pend_all, en_all, pol_all, edge_all;
  logic [NSRC-1:0] trig_all, set_all, clr_all;

  int unsigned sel_bank;
  reg_sel_e    sel_reg;
  logic        addr_ok;

  pirq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src_in),
    .q     (src_s)
  );

  always_comb begin
    sel_bank = bank_of(32'(addr));
    sel_reg  = reg_of(32'(addr));
    addr_ok  = (addr[1:0] == 2'b00) && (sel_bank < NUM_BANKS) && (sel_reg <= RS_EDGE);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && addr_ok && (sel_bank == b);
    assign set_all[b*BANK_W +: BANK_W] = (hit && sel_reg == RS_SET) ? wdata : '0;
    assign clr_all[b*BANK_W +: BANK_W] = (hit && sel_reg == RS_CLR) ? wdata : '0;

    pirq_bank #(.BW(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_s    (src_s[b*BANK_W +: BANK_W]),
      .set_mask (set_all[b*BANK_W +: BANK_W]),
      .clr_mask (clr_all[b*BANK_W +: BANK_W]),
      .we_en    (hit && sel_reg == RS_EN),
      .we_pol   (hit && sel_reg == RS_POL),
      .we_edge  (hit && sel_reg == RS_EDGE),
      .wdata    (wdata),
      .pend     (pend_all[b*BANK_W +: BANK_W]),
      .en       (en_all[b*BANK_W +: BANK_W]),
      .pol      (pol_all[b*BANK_W +: BANK_W]),
      .edg      (edge_all[b*BANK_W +: BANK_W]),
      .trig     (trig_all[b*BANK_W +: BANK_W]),
      .req      (cpu_req[b])
    );
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_ok && sel_bank == b) begin
        case (sel_reg)
          RS_STAT: rdata = pend_all[b*BANK_W +: BANK_W];
          RS_EN:   rdata = en_all[b*BANK_W +: BANK_W];
          RS_POL:  rdata = pol_all[b*BANK_W +: BANK_W];
          RS_EDGE: rdata = edge_all[b*BANK_W +: BANK_W];
          default: rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pirq_hub_chk.sv
module pirq_hub_chk #(
  parameter int NB = 5,
  parameter int BW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NB*BW-1:0] pend_all,
  input logic [NB*BW-1:0] en_all,
  input logic [NB*BW-1:0] trig_all,
  input logic [NB*BW-1:0] set_all,
  input logic [NB*BW-1:0] clr_all,
  input logic [NB-1:0]    cpu_req
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (en_all == '0 && pend_all == '0 && cpu_req == '0));

  assert_pend_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_all & ~$past(pend_all) & ~$past(trig_all | set_all)) == '0));

  assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all != '0) |=> ((pend_all & $past(clr_all & ~trig_all)) == '0));

  assert_trigger_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_all != '0) |=> ((pend_all & $past(trig_all)) == $past(trig_all)));

  assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_all & clr_all) != '0) |=> ((pend_all & $past(trig_all & clr_all)) != '0));

  assert_set_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all != '0) |=> ((pend_all & $past(set_all)) == $past(set_all)));

  assert_no_req_when_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> (cpu_req == '0));

  assert_no_req_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all == '0) |-> (cpu_req == '0));
endmodule

bind pirq_hub pirq_hub_chk #(.NB(NUM_BANKS), .BW(BANK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pend_all (pend_all),
  .en_all   (en_all),
  .trig_all (trig_all),
  .set_all  (set_all),
  .clr_all  (clr_all),
  .cpu_req  (cpu_req)
);

// File: tb/sim_pirq_hub.sv
`timescale 1ns/1ps
module sim_pirq_hub;
  localparam int NB = 5;
  localparam int BW = 32;
  localparam int NSRC = NB * BW;
  localparam int STR = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic            wr_en = 1'b0;
  logic [7:0]      addr = '0;
  logic [BW-1:0]   wdata = '0;
  logic [BW-1:0]   rdata;
  logic [NB-1:0]   cpu_req;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model of the programmable state.
  logic [NSRC-1:0] mp = '0, me = '0, mpol = '1, medg = '0, min = '0;

  always #4 clk = ~clk;

  pirq_hub u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_req(cpu_req)
  );

  function automatic logic [NSRC-1:0] act_of(input logic [NSRC-1:0] v, input logic [NSRC-1:0] p);
    return ~(v ^ p);
  endfunction

  function automatic logic [NSRC-1:0] level_hits();
    return ~medg & act_of(min, mpol);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 8'(a);
    #1;
    d = rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    int b;
    int r;
    @(negedge clk);
    addr = 8'(a); wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    b = a / STR;
    r = (a % STR) / 4;
    if (a % 4 == 0 && b < NB) begin
      case (r)
        1: me[b*BW +: BW] = d;
        2: mp[b*BW +: BW] = mp[b*BW +: BW] | d;
        3: mp[b*BW +: BW] = mp[b*BW +: BW] & ~d;
        4: mpol[b*BW +: BW] = d;
        5: medg[b*BW +: BW] = d;
        default: ;
      endcase
    end
    mp = mp | level_hits();
  endtask

  task automatic apply_src(input logic [NSRC-1:0] nv);
    logic [NSRC-1:0] old;
    old = min;
    @(negedge clk);
    src_in = nv;
    repeat (3) @(posedge clk);
    @(negedge clk);
    min = nv;
    mp = mp | (medg & act_of(nv, mpol) & ~act_of(old, mpol)) | level_hits();
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin
      rd(b*STR, d);
      chk({tag, " pending"}, d, mp[b*BW +: BW]);
      chk("R9 request", 32'(cpu_req[b]), 32'(|(mp[b*BW +: BW] & me[b*BW +: BW])));
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NSRC-1:0] v;
    int unsigned seed;
    int op;
    int b;
    seed = 32'd2024;
    d = $urandom(seed);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: reset values and register layout
    for (int k = 0; k < NB; k++) begin
      rd(k*STR + 0,  d); chk("R1 pending", d, 32'h0);
      rd(k*STR + 4,  d); chk("R1 enable", d, 32'h0);
      rd(k*STR + 16, d); chk("R1 sense", d, 32'hffff_ffff);
      rd(k*STR + 20, d); chk("R1 kind", d, 32'h0);
      rd(k*STR + 8,  d); chk("R2 set reads 0", d, 32'h0);
      rd(k*STR + 12, d); chk("R2 clr reads 0", d, 32'h0);
    end
    chk("R1 request", 32'(cpu_req), 32'h0);

    wr(2*STR + 16, 32'hffff_ffff);
    wr(2*STR + 4, 32'h1234_5678);
    rd(2*STR + 4, d); chk("R2 enable readback", d, 32'h1234_5678);
    wr(2*STR + 0, 32'hffff_ffff);
    rd(2*STR + 0, d); chk("R2 status write ignored", d, 32'h0);
    wr(2*STR + 4, 32'h0);
    me = '0;

    // R3: three-edge latency from input to pending
    @(negedge clk);
    src_in[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(0, d); chk("R3 not yet", d & 32'h8, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(0, d); chk("R3 third edge", d & 32'h8, 32'h8);
    min[3] = 1'b1; mp[3] = 1'b1;

    // R5: clear with level still active, then after release
    wr(12, 32'h8);
    rd(0, d); chk("R5 level re-asserts", d & 32'h8, 32'h8);
    v = min; v[3] = 1'b0;
    apply_src(v);
    rd(0, d); chk("R4 latched after release", d & 32'h8, 32'h8);
    wr(12, 32'h0);
    rd(0, d); chk("R5 zero mask no effect", d & 32'h8, 32'h8);
    wr(12, 32'h8);
    rd(0, d); chk("R5 cleared", d & 32'h8, 32'h0);

    // R4: active-low level
    wr(16, 32'hffff_fffd);
    rd(0, d); chk("R4 active low", d & 32'h2, 32'h2);
    wr(16, 32'hffff_ffff);
    wr(12, 32'h2);
    rd(0, d); chk("R4 low cleared", d & 32'h2, 32'h0);

    // R6: edge sources, both senses
    wr(STR + 20, 32'h20);
    v = min; v[37] = 1'b1; apply_src(v);
    rd(STR, d); chk("R6 rising", d & 32'h20, 32'h20);
    wr(STR + 12, 32'h20);
    rd(STR, d); chk("R6 clear holds with high input", d & 32'h20, 32'h0);
    v = min; v[37] = 1'b0; apply_src(v);
    rd(STR, d); chk("R6 falling ignored", d & 32'h20, 32'h0);
    wr(STR + 16, 32'hffff_ffdf);
    v = min; v[37] = 1'b1; apply_src(v);
    rd(STR, d); chk("R6 rise ignored under sense 0", d & 32'h20, 32'h0);
    v = min; v[37] = 1'b0; apply_src(v);
    rd(STR, d); chk("R6 falling under sense 0", d & 32'h20, 32'h20);
    wr(STR + 12, 32'h20);
    wr(STR + 16, 32'hffff_ffff);

    // R8 then R7: edge and clear on the same edge
    wr(STR + 8, 32'h20);
    rd(STR, d); chk("R8 set forces", d & 32'h20, 32'h20);
    @(negedge clk);
    src_in[37] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    addr = 8'(STR + 12); wdata = 32'h20; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    min[37] = 1'b1;
    rd(STR, d); chk("R7 edge beats clear", d & 32'h20, 32'h20);
    wr(STR + 12, 32'h20);
    rd(STR, d); chk("R7 plain clear", d & 32'h20, 32'h0);

    wr(4*STR + 8, 32'hA500_0001);
    rd(4*STR, d); chk("R8 set mask", d, 32'hA500_0001);

    // R9: request tracks enable
    wr(4*STR + 4, 32'h0000_0100);
    chk("R9 no overlap", 32'(cpu_req[4]), 32'h0);
    wr(4*STR + 4, 32'h0000_0001);
    chk("R9 overlap", 32'(cpu_req[4]), 32'h1);
    wr(4*STR + 12, 32'h1);
    chk("R9 drop after clear", 32'(cpu_req[4]), 32'h0);

    // R10: bank isolation and invalid addresses
    wr(3*STR + 4, 32'hdead_beef);
    wr(NB*STR + 4, 32'hffff_ffff);
    wr(3*STR + 5, 32'h0);
    for (int k = 0; k < NB; k++) begin
      rd(k*STR + 4, d); chk("R10 enables", d, me[k*BW +: BW]);
    end
    rd(NB*STR + 4, d); chk("R10 out of range read", d, 32'h0);
    check_all("R10");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      op = int'($urandom % 7);
      b  = int'($urandom % NB);
      case (op)
        0, 1: begin
          v = min;
          for (int k = 0; k < NB; k++) v[k*BW +: BW] = v[k*BW +: BW] ^ ($urandom & $urandom);
          apply_src(v);
        end
        2: wr(b*STR + 4, $urandom);
        3: wr(b*STR + 16, $urandom);
        4: wr(b*STR + 20, $urandom);
        5: wr(b*STR + 8, $urandom & $urandom & $urandom);
        default: wr(b*STR + 12, $urandom);
      endcase
      check_all("R6 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule